// File: doc/BRIEF.md
# Triggered Switch-Control Register File

This block holds the register state behind a serial front-end control slave for a four-port RF switch. A bus front end decodes each transaction into a single-cycle write strobe with an address and a data byte, or into a read address. The block answers reads combinationally from its registers. Writes to the switch register can be staged in a shadow copy and committed later by a trigger strobe, or they can be applied at once when that trigger is masked.

The block also keeps the power-mode field, the sticky error flags, a group identifier and the programmable slave identifier. It turns the committed switch byte into four port enables and a ground-short enable. Those outputs are held at isolation whenever the power mode is anything other than normal. The device comes out of reset in low power, so a separate write is needed before any port closes.

Top module: `rfsw_regfile`

## Requirements
- R1: After reset the registers read as follows: address 0x00 reads 0x00, 0x1A reads 0x00, 0x1B reads 0x00, 0x1C reads 0x80 (power field 2'b10, low power), 0x1D reads 0x1C, 0x1E reads 0x1A, and 0x1F reads {2'b00, 2'b01, id}. The id is 4'hC when `usid_alt` is 0 during reset and 4'hD when it is 1.
- R2: While the mask bit of the switch register's trigger (0x1C bit 3+TRIG_SEL, default bit 3) is clear, a write to 0x00 goes only to the shadow copy. Reads of 0x00 and the port outputs stay unchanged.
- R3: A write to 0x1C with strobe bit TRIG_SEL set and mask bit 3+TRIG_SEL clear in the same byte copies the shadow into the active switch register. Strobe bits 2:0 always read back 0.
- R4: While the stored mask bit is set, a write to 0x00 updates the active switch register in the same cycle.
- R5: The power field is 0x1C bits 7:6, with 00 meaning normal and 10 meaning low power. `port_en` and `gnd_short` are zero unless the field is 00, and the active switch value is kept while they are forced.
- R6: Writing 0x1C with field 01 (restore defaults) sets the field to 01 and clears the active switch register, the shadow and the three mask bits.
- R7: Writing 0x1C with field 11 (reserved) leaves the power field unchanged but still updates the mask bits.
- R8: In normal mode, `port_en[i]` equals active bit i for i = 0 to 3, and value 0 means isolation. When active bit 6 is set, `gnd_short` is 1 and every `port_en` bit is 0.
- R9: Writing 0x1A with bit 7 set returns every register to its R1 value. Bit 7 reads back 0.
- R10: Each `err_set` pulse sets the matching sticky flag in 0x1A bits 6:0. Bus writes to 0x1A without bit 7 leave those flags unchanged.
- R11: Writes to 0x1D, 0x1E, and to bits 7:4 of 0x1F never change what those bits read.
- R12: The slave id in 0x1F bits 3:0 changes only on a write to 0x1F with data bits 5:4 = 2'b01 that directly follows a write to 0x1D and then a write to 0x1E, with no other write in between.
- R13: 0x1B stores bits 3:0 as the group id, and bits 7:4 read 0.
- R14: Addresses other than those listed read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usid_alt | input | 1 | Pin-strap choosing the default slave id |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| err_set | input | 7 | Error flag set pulses from the front end |
| rd_data | output | 8 | Read data |
| port_en | output | 4 | Per-port connection enables |
| gnd_short | output | 1 | Common port ground-short enable |
| usid | output | 4 | Current slave id |
| gsid | output | 4 | Current group id |
| pwr_mode | output | 2 | Current power field |

## Verification
The assertions assume that each write lasts one cycle, that `usid_alt` only changes while reset is held, and that `err_set` is never pulsed in the same cycle as a software-reset write. The stimulus keeps to these rules. Writes are driven for exactly one clock, the pin strap changes only inside a reset pulse, and error pulses are issued only in idle cycles. Random writes are drawn over the decoded addresses plus one unused address. These are mixed with directed sequences for trigger commit, mask bypass, the reserved and restore power codes, and complete and broken id-programming sequences.

// File: rtl/rfsw_regfile.sv
module rfsw_regfile #(
  parameter int TRIG_SEL = 0,
  parameter logic [3:0] USID_PIN0 = 4'hC,
  parameter logic [3:0] USID_PIN1 = 4'hD,
  parameter logic [7:0] PROD_ID = 8'h1C,
  parameter logic [7:0] MFR_LO = 8'h1A,
  parameter logic [1:0] MFR_HI = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       usid_alt,
  input  logic       wr_en,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [4:0] rd_addr,
  input  logic [6:0] err_set,
  output logic [7:0] rd_data,
  output logic [3:0] port_en,
  output logic       gnd_short,
  output logic [3:0] usid,
  output logic [3:0] gsid,
  output logic [1:0] pwr_mode
);
  localparam logic [4:0] A_SW = 5'h00, A_ST = 5'h1A, A_GID = 5'h1B,
                         A_PM = 5'h1C, A_PID = 5'h1D, A_MID = 5'h1E, A_UID = 5'h1F;
  localparam int MASK_BIT = 3 + TRIG_SEL;

  logic [7:0] act_q, shd_q;
  logic [1:0] pwr_q, step_q;
  logic [2:0] mask_q;
  logic [3:0] gid_q, usid_q;
  logic [6:0] err_q;

  wire wr_sw  = wr_en && wr_addr == A_SW;
  wire wr_pm  = wr_en && wr_addr == A_PM;
  wire wr_gid = wr_en && wr_addr == A_GID;
  wire wr_uid = wr_en && wr_addr == A_UID;
  wire swrst  = wr_en && wr_addr == A_ST && wr_data[7];
  wire pm_restore = wr_pm && wr_data[7:6] == 2'b01;
  wire trig_fire  = wr_pm && !pm_restore && wr_data[TRIG_SEL] && !wr_data[MASK_BIT];
  wire usid_commit = wr_uid && step_q == 2'd2 && wr_data[5:4] == MFR_HI;
  wire [3:0] usid_def = usid_alt ? USID_PIN1 : USID_PIN0;
  wire normal = pwr_q == 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0; shd_q <= '0; pwr_q <= 2'b10; mask_q <= '0;
      gid_q <= '0; err_q <= '0; step_q <= '0; usid_q <= usid_def;
    end else if (swrst) begin
      act_q <= '0; shd_q <= '0; pwr_q <= 2'b10; mask_q <= '0;
      gid_q <= '0; err_q <= '0; step_q <= '0; usid_q <= usid_def;
    end else begin
      err_q <= err_q | err_set;
      if (wr_sw) begin
        shd_q <= wr_data;
        if (mask_q[TRIG_SEL]) act_q <= wr_data;
      end
      if (pm_restore) begin
        pwr_q <= 2'b01; mask_q <= '0; act_q <= '0; shd_q <= '0;
      end else if (wr_pm) begin
        if (wr_data[7:6] != 2'b11) pwr_q <= wr_data[7:6];
        mask_q <= wr_data[5:3];
        if (trig_fire) act_q <= shd_q;
      end
      if (wr_gid) gid_q <= wr_data[3:0];
      if (usid_commit) usid_q <= wr_data[3:0];
      if (wr_en)
        step_q <= (wr_addr == A_PID) ? 2'd1 :
                  (wr_addr == A_MID && step_q == 2'd1) ? 2'd2 : 2'd0;
    end
  end

  assign gnd_short = normal && act_q[6];
  assign port_en   = (normal && !act_q[6]) ? act_q[3:0] : 4'h0;
  assign usid = usid_q;
  assign gsid = gid_q;
  assign pwr_mode = pwr_q;

  always_comb begin
    case (rd_addr)
      A_SW:    rd_data = act_q;
      A_ST:    rd_data = {1'b0, err_q};
      A_GID:   rd_data = {4'h0, gid_q};
      A_PM:    rd_data = {pwr_q, mask_q, 3'b000};
      A_PID:   rd_data = PROD_ID;
      A_MID:   rd_data = MFR_LO;
      A_UID:   rd_data = {2'b00, MFR_HI, usid_q};
      default: rd_data = 8'h00;
    endcase
  end

  assert_staged_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sw && !mask_q[TRIG_SEL]) |=> act_q == $past(act_q));
  assert_trigger_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> act_q == $past(shd_q));
  assert_mask_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sw && mask_q[TRIG_SEL]) |=> act_q == $past(wr_data));
  assert_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'b00) |-> (port_en == 4'h0 && !gnd_short));
  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !swrst |=> err_q == ($past(err_q) | $past(err_set)));
  assert_usid_guard_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!usid_commit && !swrst) |=> $stable(usid));
endmodule

// File: tb/rfsw_regfile_test.sv
module rfsw_regfile_test;
  logic clk = 0, rst_n = 0, usid_alt = 0, wr_en = 0;
  logic [4:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] err_set = 0;
  logic [7:0] rd_data;
  logic [3:0] port_en, usid, gsid;
  logic gnd_short;
  logic [1:0] pwr_mode;

  always #10 clk = ~clk;

  rfsw_regfile uut (.clk(clk), .rst_n(rst_n), .usid_alt(usid_alt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .err_set(err_set),
    .rd_data(rd_data), .port_en(port_en), .gnd_short(gnd_short), .usid(usid),
    .gsid(gsid), .pwr_mode(pwr_mode));

  int checks = 0, fails = 0;
  logic [7:0] m_act, m_shd;
  logic [1:0] m_pwr, m_step;
  logic [2:0] m_mask;
  logic [3:0] m_gid, m_usid;
  logic [6:0] m_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_act = 0; m_shd = 0; m_pwr = 2'b10; m_mask = 0; m_gid = 0; m_err = 0;
    m_step = 0; m_usid = usid_alt ? 4'hD : 4'hC;
  endtask

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    case (a)
      5'h00: return m_act;
      5'h1A: return {1'b0, m_err};
      5'h1B: return {4'h0, m_gid};
      5'h1C: return {m_pwr, m_mask, 3'b000};
      5'h1D: return 8'h1C;
      5'h1E: return 8'h1A;
      5'h1F: return {4'b0001, m_usid};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_ports();
    return (m_pwr == 2'b00 && !m_act[6]) ? m_act[3:0] : 4'h0;
  endfunction

  task automatic m_write(input logic [4:0] a, input logic [7:0] d);
    logic [1:0] nstep;
    nstep = (a == 5'h1D) ? 2'd1 : (a == 5'h1E && m_step == 2'd1) ? 2'd2 : 2'd0;
    if (a == 5'h1A && d[7]) begin m_reset(); return; end
    if (a == 5'h00) begin m_shd = d; if (m_mask[0]) m_act = d; end
    if (a == 5'h1C) begin
      if (d[7:6] == 2'b01) begin m_pwr = 2'b01; m_mask = 0; m_act = 0; m_shd = 0; end
      else begin
        if (d[7:6] != 2'b11) m_pwr = d[7:6];
        m_mask = d[5:3];
        if (d[0] && !d[3]) m_act = m_shd;
      end
    end
    if (a == 5'h1B) m_gid = d[3:0];
    if (a == 5'h1F && m_step == 2'd2 && d[5:4] == 2'b01) m_usid = d[3:0];
    m_step = nstep;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    m_write(a, d);
  endtask

  task automatic pulse_err(input logic [6:0] v);
    err_set = v;
    @(negedge clk);
    err_set = 0;
    m_err = m_err | v;
  endtask

  task automatic check_all(input string req);
    logic [4:0] addrs [8] = '{5'h00, 5'h1A, 5'h1B, 5'h1C, 5'h1D, 5'h1E, 5'h1F, 5'h05};
    foreach (addrs[i]) begin
      rd_addr = addrs[i];
      #1;
      chk(req, rd_data, exp_rd(addrs[i]));
    end
    chk(req, port_en, exp_ports());
    chk(req, gnd_short, m_pwr == 2'b00 && m_act[6]);
    chk(req, usid, m_usid);
    chk(req, gsid, m_gid);
    chk(req, pwr_mode, m_pwr);
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst_n = 0; usid_alt = alt;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reset();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] pool [9] = '{5'h00, 5'h00, 5'h1A, 5'h1B, 5'h1C, 5'h1D, 5'h1E, 5'h1F, 5'h07};
    void'($urandom(32'd4242));
    do_reset(1'b0);
    check_all("R1 reset");

    wr(5'h1C, 8'h00); check_all("R5 normal");
    wr(5'h00, 8'h05); check_all("R2 staged");
    wr(5'h1C, 8'h01); check_all("R3 trigger");
    wr(5'h1C, 8'h08); wr(5'h00, 8'h0A); check_all("R4 bypass");
    wr(5'h00, 8'h4F); check_all("R8 ground short");
    wr(5'h00, 8'h0F); check_all("R8 all ports");
    wr(5'h1C, 8'hC0); check_all("R7 reserved");
    wr(5'h1C, 8'h88); check_all("R5 low power keeps value");
    wr(5'h1C, 8'h40); check_all("R6 restore");
    wr(5'h1D, 8'hFF); wr(5'h1E, 8'hFF); wr(5'h1F, 8'hF3); check_all("R11 ids");
    wr(5'h1D, 8'h00); wr(5'h1B, 8'h00); wr(5'h1E, 8'h00); wr(5'h1F, 8'h16); check_all("R12 broken");
    wr(5'h1D, 8'h00); wr(5'h1E, 8'h00); wr(5'h1F, 8'h17); check_all("R12 programmed");
    wr(5'h1B, 8'hFF); check_all("R13 group");
    wr(5'h05, 8'hFF); check_all("R14 unused");
    pulse_err(7'h25); check_all("R10 set");
    wr(5'h1A, 8'h7F); check_all("R10 write ignored");
    wr(5'h1A, 8'h80); check_all("R9 software reset");

    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      logic [7:0] d;
      a = pool[$urandom_range(0, 8)];
      d = 8'($urandom);
      if (a == 5'h1A && $urandom_range(0, 3) != 0) d[7] = 1'b0;
      wr(a, d);
      if ($urandom_range(0, 9) == 0) pulse_err(7'($urandom));
      check_all("random R2 R3 R4 R7 R12");
    end

    do_reset(1'b1);
    check_all("R1 alternate id");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule